// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings a display panel's timing controller up and down in a fixed order. On a power-up request it issues a chain of single-cycle register writes and timed pauses. The chain raises the panel rails in order and enables the picture-control and common-voltage signals. Partway through, it hands one byte to a separate common-voltage DAC writer and waits for that writer to finish. It then programs phase, polarity and resolution. On a power-down request it waits two frame times, lowers the rails in the reverse dependency order, and returns the common-voltage DAC to zero.

The block remembers whether the panel has been fully brought up. A later power-up request while the panel is up only reprograms phase and resolution for the new mode. Pauses are measured in milliseconds by a prescaler sized from the clock frequency parameter. Requests that arrive while a sequence is running are dropped.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset `wr_en`, `dac_start`, `busy` and `panel_up` are all 0.
- R2: A power-up request while `panel_up` is 0 yields exactly these writes in order (address, data): (6,1F) (3,03) (4,00) (4,04) (3,07) (6,09) (3,17) (4,06) (6,01) (3,1F) (4,07) (6,00) (1,phase) (7,00) (0,res). Address 6 is picture control, 3 is power register 0, 4 is power register 1, 1 is phase, 7 is polarity and 0 is resolution. Addresses 2 and 5 are never written.
- R3: The pause between (4,04) and (3,07) lasts at least 3 ms. The pause between (4,06) and (6,01) lasts at least 2 ms. The pause between (7,00) and the resolution write lasts at least 1 ms. One ms is `CLK_KHZ` clock cycles, and each pause adds no more than 4 cycles.
- R4: During power-up, between the (6,09) and (3,17) writes, `dac_start` pulses for one cycle. `dac_data` then holds the stored common-voltage value if `vcom_valid` is 1, otherwise 125. No write and no second pulse occurs until `dac_done`.
- R5: The phase byte is 0x13 (value 9 shifted left once, bit 0 set) in QVGA mode (`mode_vga`=0). In VGA mode it is `{phase_val[3:0],1}` when `phase_valid` is 1, and 0x01 otherwise.
- R6: The resolution byte is 0x00 for VGA and 0x01 for QVGA. It is the last write of a power-up, and `panel_up` becomes 1 when the sequence completes.
- R7: A power-up request while `panel_up` is 1 yields only the phase write and then the resolution write, with no DAC handoff.
- R8: A power-down request waits at least 34 ms. It then writes (4,06) (6,08) (3,14), hands the DAC the value 0, then writes (4,04) (3,04) (6,1E) (3,00) (4,00). At the end `panel_up` becomes 0.
- R9: Requests are taken only while `busy` is 0. Requests made while `busy` is 1 produce no write and no DAC pulse.
- R10: If both requests arrive in the same idle cycle, power-down is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_req | input | 1 | Request panel power-up or mode change |
| pwr_dn_req | input | 1 | Request panel power-down |
| mode_vga | input | 1 | 1 = VGA, 0 = QVGA; sampled with the request |
| vcom_val | input | 8 | Stored common-voltage setting |
| vcom_valid | input | 1 | `vcom_val` holds a stored value |
| phase_val | input | 8 | Stored phase adjust value |
| phase_valid | input | 1 | `phase_val` holds a stored value |
| dac_done | input | 1 | DAC writer finished its transfer |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 3 | Register address of the write |
| wr_data | output | 8 | Register data of the write |
| dac_start | output | 1 | One-cycle request to the DAC writer |
| dac_data | output | 8 | Byte for the DAC writer |
| busy | output | 1 | A sequence is running |
| panel_up | output | 1 | Panel fully brought up |

## Verification
The assertions assume that the DAC writer answers each `dac_start` with exactly one `dac_done` pulse, and that it never raises `dac_done` when no transfer is pending. The bench's DAC model enforces this by answering each start once, after a fixed delay. Requests are one-cycle pulses driven between clock edges, and some of them are deliberately placed inside a running sequence. The stored values are held steady around each request, because the block samples them only at acceptance.

// File: rtl/panel_pwr_pkg.sv
package panel_pwr_pkg;

    localparam int IDX_W = 5;
    localparam int MS_W  = 6;

    // timing-controller register addresses
    localparam logic [2:0] A_RES   = 3'd0;
    localparam logic [2:0] A_PHASE = 3'd1;
    localparam logic [2:0] A_PWR0  = 3'd3;
    localparam logic [2:0] A_PWR1  = 3'd4;
    localparam logic [2:0] A_PIC   = 3'd6;
    localparam logic [2:0] A_POL   = 3'd7;

    // power register 0 bits
    localparam logic [7:0] P0_CLK  = 8'h01;
    localparam logic [7:0] P0_DOUT = 8'h02;
    localparam logic [7:0] P0_DAC  = 8'h04;
    localparam logic [7:0] P0_COM  = 8'h08;
    localparam logic [7:0] P0_VCC5 = 8'h10;

    // power register 1 bits
    localparam logic [7:0] P1_VW   = 8'h01;
    localparam logic [7:0] P1_GVSS = 8'h02;
    localparam logic [7:0] P1_VDD  = 8'h04;

    // picture control bits
    localparam logic [7:0] PC_INIT   = 8'h01;
    localparam logic [7:0] PC_INIOFF = 8'h02;
    localparam logic [7:0] PC_PDOWN  = 8'h04;
    localparam logic [7:0] PC_COMOFF = 8'h08;
    localparam logic [7:0] PC_DACOFF = 8'h10;

    localparam logic [7:0] VCOM_DEFAULT = 8'd125;
    localparam logic [3:0] QVGA_PHASE   = 4'd9;

    // step indices with special meaning
    localparam logic [IDX_W-1:0] IDX_PHASE  = 5'd15;
    localparam logic [IDX_W-1:0] IDX_RES    = 5'd18;
    localparam logic [IDX_W-1:0] IDX_UP_END = 5'd19;
    localparam logic [IDX_W-1:0] IDX_DOWN   = 5'd20;

    typedef enum logic [1:0] {K_WRITE, K_WAIT, K_DAC, K_END} step_kind_e;

    typedef struct packed {
        step_kind_e        kind;
        logic [2:0]        addr;
        logic [7:0]        data;
        logic [MS_W-1:0]   ms;
    } step_t;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAITMS, S_DACW} seq_state_e;

    function automatic logic [7:0] phase_byte(input logic vga, input logic valid,
                                              input logic [7:0] v);
        if (!vga)      return {3'b000, QVGA_PHASE, 1'b1};
        else if (valid) return {3'b000, v[3:0], 1'b1};
        else           return 8'h01;
    endfunction

    function automatic step_t mk(input step_kind_e k, input logic [2:0] a,
                                 input logic [7:0] d, input logic [MS_W-1:0] m);
        step_t s;
        s.kind = k; s.addr = a; s.data = d; s.ms = m;
        return s;
    endfunction

endpackage

// File: rtl/pps_ms_timer.sv
module pps_ms_timer
    import panel_pwr_pkg::*;
#(
    parameter int CLK_KHZ = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [MS_W-1:0] ms_in,
    output logic            done
);
    localparam int PW = (CLK_KHZ > 1) ? $clog2(CLK_KHZ) : 1;
    localparam logic [PW-1:0] RELOAD = PW'(CLK_KHZ - 1);

    logic [PW-1:0]   pre;
    logic [MS_W-1:0] ms_left;
    logic            active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            pre     <= '0;
            ms_left <= '0;
        end else if (start) begin
            active  <= 1'b1;
            pre     <= RELOAD;
            ms_left <= ms_in;
        end else if (active) begin
            if (pre == '0) begin
                if (ms_left <= MS_W'(1)) begin
                    active <= 1'b0;
                end else begin
                    ms_left <= ms_left - MS_W'(1);
                    pre     <= RELOAD;
                end
            end else begin
                pre <= pre - PW'(1);
            end
        end
    end

    assign done = active && (pre == '0) && (ms_left <= MS_W'(1));
endmodule

// File: rtl/pps_step_rom.sv
module pps_step_rom
    import panel_pwr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             vga,
    input  logic [7:0]       phase_b,
    input  logic [7:0]       vcom_b,
    output step_t            step
);
    always_comb begin
        unique case (idx)
            // power-up
            5'd0:  step = mk(K_WRITE, A_PIC,  PC_PDOWN | PC_INIOFF | PC_INIT | PC_COMOFF | PC_DACOFF, '0);
            5'd1:  step = mk(K_WRITE, A_PWR0, P0_CLK | P0_DOUT, '0);
            5'd2:  step = mk(K_WRITE, A_PWR1, 8'h00, '0);
            5'd3:  step = mk(K_WRITE, A_PWR1, P1_VDD, '0);
            5'd4:  step = mk(K_WAIT,  A_RES,  8'h00, MS_W'(3));
            5'd5:  step = mk(K_WRITE, A_PWR0, P0_CLK | P0_DOUT | P0_DAC, '0);
            5'd6:  step = mk(K_WRITE, A_PIC,  PC_INIT | PC_COMOFF, '0);
            5'd7:  step = mk(K_DAC,   A_RES,  vcom_b, '0);
            5'd8:  step = mk(K_WRITE, A_PWR0, P0_CLK | P0_DOUT | P0_DAC | P0_VCC5, '0);
            5'd9:  step = mk(K_WRITE, A_PWR1, P1_GVSS | P1_VDD, '0);
            5'd10: step = mk(K_WAIT,  A_RES,  8'h00, MS_W'(2));
            5'd11: step = mk(K_WRITE, A_PIC,  PC_INIT, '0);
            5'd12: step = mk(K_WRITE, A_PWR0, P0_CLK | P0_DOUT | P0_DAC | P0_COM | P0_VCC5, '0);
            5'd13: step = mk(K_WRITE, A_PWR1, P1_VW | P1_GVSS | P1_VDD, '0);
            5'd14: step = mk(K_WRITE, A_PIC,  8'h00, '0);
            5'd15: step = mk(K_WRITE, A_PHASE, phase_b, '0);
            5'd16: step = mk(K_WRITE, A_POL,  8'h00, '0);
            5'd17: step = mk(K_WAIT,  A_RES,  8'h00, MS_W'(1));
            5'd18: step = mk(K_WRITE, A_RES,  vga ? 8'h00 : 8'h01, '0);
            // power-down
            5'd20: step = mk(K_WAIT,  A_RES,  8'h00, MS_W'(34));
            5'd21: step = mk(K_WRITE, A_PWR1, P1_GVSS | P1_VDD, '0);
            5'd22: step = mk(K_WRITE, A_PIC,  PC_COMOFF, '0);
            5'd23: step = mk(K_WRITE, A_PWR0, P0_DAC | P0_VCC5, '0);
            5'd24: step = mk(K_DAC,   A_RES,  8'h00, '0);
            5'd25: step = mk(K_WRITE, A_PWR1, P1_VDD, '0);
            5'd26: step = mk(K_WRITE, A_PWR0, P0_DAC, '0);
            5'd27: step = mk(K_WRITE, A_PIC,  PC_INIOFF | PC_DACOFF | PC_PDOWN | PC_COMOFF, '0);
            5'd28: step = mk(K_WRITE, A_PWR0, 8'h00, '0);
            5'd29: step = mk(K_WRITE, A_PWR1, 8'h00, '0);
            default: step = mk(K_END, A_RES, 8'h00, '0);
        endcase
    end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import panel_pwr_pkg::*;
#(
    parameter int CLK_KHZ = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_up_req,
    input  logic       pwr_dn_req,
    input  logic       mode_vga,
    input  logic [7:0] vcom_val,
    input  logic       vcom_valid,
    input  logic [7:0] phase_val,
    input  logic       phase_valid,
    input  logic       dac_done,
    output logic       wr_en,
    output logic [2:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       dac_start,
    output logic [7:0] dac_data,
    output logic       busy,
    output logic       panel_up
);
    seq_state_e       st;
    logic [IDX_W-1:0] idx;
    logic             short_q;
    logic             vga_q;
    logic [7:0]       phase_q;
    logic [7:0]       vcom_q;
    step_t            cur;
    logic             tmr_start;
    logic             tmr_done;

    pps_step_rom u_rom (
        .idx     (idx),
        .vga     (vga_q),
        .phase_b (phase_q),
        .vcom_b  (vcom_q),
        .step    (cur)
    );

    assign tmr_start = (st == S_RUN) && (cur.kind == K_WAIT);

    pps_ms_timer #(.CLK_KHZ(CLK_KHZ)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .ms_in (cur.ms),
        .done  (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            idx       <= '0;
            short_q   <= 1'b0;
            vga_q     <= 1'b0;
            phase_q   <= '0;
            vcom_q    <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            dac_start <= 1'b0;
            dac_data  <= '0;
            panel_up  <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            dac_start <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (pwr_dn_req) begin
                        st      <= S_RUN;
                        idx     <= IDX_DOWN;
                        short_q <= 1'b0;
                    end else if (pwr_up_req) begin
                        st      <= S_RUN;
                        idx     <= panel_up ? IDX_PHASE : '0;
                        short_q <= panel_up;
                        vga_q   <= mode_vga;
                        phase_q <= phase_byte(mode_vga, phase_valid, phase_val);
                        vcom_q  <= vcom_valid ? vcom_val : VCOM_DEFAULT;
                    end
                end
                S_RUN: begin
                    unique case (cur.kind)
                        K_WRITE: begin
                            wr_en   <= 1'b1;
                            wr_addr <= cur.addr;
                            wr_data <= cur.data;
                            idx     <= (short_q && idx == IDX_PHASE) ? IDX_RES
                                                                     : idx + IDX_W'(1);
                        end
                        K_WAIT: st <= S_WAITMS;
                        K_DAC: begin
                            dac_start <= 1'b1;
                            dac_data  <= cur.data;
                            st        <= S_DACW;
                        end
                        K_END: begin
                            st       <= S_IDLE;
                            panel_up <= (idx == IDX_UP_END);
                        end
                    endcase
                end
                S_WAITMS: begin
                    if (tmr_done) begin
                        st  <= S_RUN;
                        idx <= idx + IDX_W'(1);
                    end
                end
                S_DACW: begin
                    if (dac_done) begin
                        st  <= S_RUN;
                        idx <= idx + IDX_W'(1);
                    end
                end
            endcase
        end
    end

    assign busy = (st != S_IDLE);
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic       dac_start,
    input logic       dac_done,
    input logic       busy,
    input logic       panel_up
);
    logic dac_pending;

    always_ff @(posedge clk) begin
        if (rst)            dac_pending <= 1'b0;
        else if (dac_start) dac_pending <= 1'b1;
        else if (dac_done)  dac_pending <= 1'b0;
    end

    AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr != 3'd2 && wr_addr != 3'd5)); // R2

    AST_DAC_QUIET: assert property (@(posedge clk) disable iff (rst)
        dac_pending |-> (!wr_en && !dac_start)); // R4

    AST_DAC_PULSE: assert property (@(posedge clk) disable iff (rst)
        dac_start |=> !dac_start); // R4

    AST_WR_DAC_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dac_start)); // R4

    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wr_en || dac_start) |-> busy); // R9

    AST_UP_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(panel_up) |-> !busy); // R6

    AST_DOWN_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(panel_up) |-> !busy); // R8
endmodule

bind panel_pwr_seq pps_checker i_pps_checker (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .dac_start (dac_start),
    .dac_done  (dac_done),
    .busy      (busy),
    .panel_up  (panel_up)
);

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;
    localparam int K = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_up_req = 1'b0, pwr_dn_req = 1'b0, mode_vga = 1'b0;
    logic [7:0] vcom_val = '0, phase_val = '0;
    logic       vcom_valid = 1'b0, phase_valid = 1'b0, dac_done = 1'b0;
    logic       wr_en, dac_start, busy, panel_up;
    logic [2:0] wr_addr;
    logic [7:0] wr_data, dac_data;

    panel_pwr_seq #(.CLK_KHZ(K)) i_panel_pwr_seq (
        .clk(clk), .rst(rst), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
        .mode_vga(mode_vga), .vcom_val(vcom_val), .vcom_valid(vcom_valid),
        .phase_val(phase_val), .phase_valid(phase_valid), .dac_done(dac_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dac_start(dac_start), .dac_data(dac_data), .busy(busy), .panel_up(panel_up)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // write and DAC logs
    logic [2:0] la [0:63];
    logic [7:0] ld [0:63];
    int         lc [0:63];
    int         n_wr = 0, n_dac = 0, dac_at = -1, req_cyc = 0;
    logic [7:0] dac_val = '0;
    logic [2:0] ea [0:31];
    logic [7:0] ed [0:31];

    // monitor and DAC writer model
    int dac_cnt = 0;
    always @(negedge clk) begin
        if (wr_en && n_wr < 64) begin
            la[n_wr] = wr_addr; ld[n_wr] = wr_data; lc[n_wr] = cyc;
            n_wr = n_wr + 1;
        end
        dac_done <= 1'b0;
        if (dac_start) begin
            n_dac = n_dac + 1; dac_val = dac_data; dac_at = n_wr; dac_cnt = 5;
        end else if (dac_cnt > 0) begin
            dac_cnt = dac_cnt - 1;
            if (dac_cnt == 0) dac_done <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        n_wr = 0; n_dac = 0; dac_at = -1;
    endtask

    task automatic pulse(input bit up, input bit dn);
        @(negedge clk);
        pwr_up_req = up; pwr_dn_req = dn; req_cyc = cyc;
        @(negedge clk);
        pwr_up_req = 1'b0; pwr_dn_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_seq(input string tag, input int n);
        chk(n_wr == n, {tag, " write count"}, n_wr, n);
        for (int i = 0; i < n && i < n_wr; i++) begin
            chk(la[i] == ea[i], {tag, " addr"}, la[i], ea[i]);
            chk(ld[i] == ed[i], {tag, " data"}, ld[i], ed[i]);
        end
    endtask

    task automatic gap(input int a, input int ms, input string tag);
        int g;
        g = lc[a+1] - lc[a];
        chk(g >= ms*K && g <= ms*K + 4, tag, g, ms*K);
    endtask

    task automatic set_up_exp(input logic [7:0] ph, input logic [7:0] res);
        logic [2:0] a [0:14] = '{6,3,4,4,3,6,3,4,6,3,4,6,1,7,0};
        logic [7:0] d [0:14] = '{8'h1F,8'h03,8'h00,8'h04,8'h07,8'h09,8'h17,8'h06,
                                 8'h01,8'h1F,8'h07,8'h00,8'h00,8'h00,8'h00};
        for (int i = 0; i < 15; i++) begin ea[i] = a[i]; ed[i] = d[i]; end
        ed[12] = ph; ed[14] = res;
    endtask

    task automatic set_dn_exp();
        logic [2:0] a [0:7] = '{4,6,3,4,3,6,3,4};
        logic [7:0] d [0:7] = '{8'h06,8'h08,8'h14,8'h04,8'h04,8'h1E,8'h00,8'h00};
        for (int i = 0; i < 8; i++) begin ea[i] = a[i]; ed[i] = d[i]; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!wr_en && !dac_start, "R1 strobes idle", wr_en, 0);
        chk(!busy, "R1 busy", busy, 0);
        chk(!panel_up, "R1 panel_up", panel_up, 0);
    endtask

    task automatic t_full_up_vga();
        clr_log();
        mode_vga = 1; vcom_val = 8'h50; vcom_valid = 1; phase_val = 8'h2B; phase_valid = 1;
        pulse(1, 0);
        wait_idle();
        set_up_exp(8'h17, 8'h00);
        cmp_seq("R2 R5 R6 full up VGA", 15);
        gap(3, 3, "R3 3ms pause");
        gap(7, 2, "R3 2ms pause");
        gap(13, 1, "R3 1ms pause");
        chk(n_dac == 1 && dac_at == 6, "R4 DAC handoff position", dac_at, 6);
        chk(dac_val == 8'h50, "R4 stored vcom", dac_val, 8'h50);
        chk(panel_up, "R6 panel_up set", panel_up, 1);
    endtask

    task automatic t_reinit(input bit vga, input bit pv, input logic [7:0] ph, input logic [7:0] res);
        clr_log();
        mode_vga = vga; phase_valid = pv; phase_val = 8'h2B;
        pulse(1, 0);
        wait_idle();
        ea[0] = 3'd1; ed[0] = ph; ea[1] = 3'd0; ed[1] = res;
        cmp_seq("R7 R5 R6 re-init", 2);
        chk(n_dac == 0, "R7 no DAC on re-init", n_dac, 0);
        chk(panel_up, "R7 panel_up kept", panel_up, 1);
    endtask

    task automatic t_power_down(input bit both);
        clr_log();
        pulse(both, 1);
        wait_idle();
        set_dn_exp();
        cmp_seq(both ? "R10 both requests" : "R8 power down", 8);
        if (n_wr > 0)
            chk(lc[0] - req_cyc >= 34*K, "R8 34ms pause", lc[0] - req_cyc, 34*K);
        chk(n_dac == 1 && dac_at == 3 && dac_val == 8'h00, "R8 DAC zero", dac_val, 0);
        chk(!panel_up, "R8 panel_up cleared", panel_up, 0);
    endtask

    task automatic t_up_qvga_busy();
        clr_log();
        mode_vga = 0; vcom_valid = 0; vcom_val = 8'h33; phase_valid = 1; phase_val = 8'h2B;
        pulse(1, 0);
        repeat (10) @(negedge clk);
        pulse(0, 1);                       // R9: ignored while busy
        repeat (3*K + 20) @(negedge clk);
        pulse(1, 1);                       // R9: ignored while busy
        wait_idle();
        set_up_exp(8'h13, 8'h01);
        cmp_seq("R9 R5 QVGA up with busy requests", 15);
        chk(dac_val == 8'd125, "R4 default vcom", dac_val, 125);
        chk(panel_up, "R9 still up", panel_up, 1);
        repeat (50) @(negedge clk);
        chk(n_wr == 15 && !busy, "R9 no late sequence", n_wr, 15);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_up_vga();
        t_reinit(0, 1, 8'h13, 8'h01);
        t_reinit(1, 0, 8'h01, 8'h00);
        t_power_down(0);
        t_up_qvga_busy();
        t_power_down(1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule